// File: doc/BRIEF.md
# Page-Mapping Address Translation Unit

This block widens a 16-bit processor address to a 24-bit physical address, which covers a 16 MB space. The top four bits of the logical address pick one of sixteen entries in a small mapping table. The entry's 12-bit page number takes the place of those four bits. The low twelve bits pass through as the offset inside a 4 KB page. At any moment the processor sees sixteen pages of its choosing through its ordinary 16-bit addressing. It changes which pages are visible by rewriting table entries.

Table entries are written through a simple port that takes an index, data and an enable. A separate read port returns any entry, so software can check a mapping. Each translation is looked up from the table as it stands in the cycle of the request, and the result is registered. The physical address and its valid flag therefore appear one cycle after the logical address. The table comes out of reset as an identity map, so the first 64 KB of physical memory are visible without any setup.

Top module: `pmap_xlate`

## Requirements
- R1: While reset is high and in the cycle after it, `pa_valid` is 0, `pa_addr` is 0 and `tr_data` is 0. After reset, entry i holds page number i for every i in 0..15, so a request in page i is translated to physical page i.
- R2: One cycle after a request with `la_valid` high, `pa_addr[11:0]` equals bits [11:0] of that request's `la_addr`.
- R3: One cycle after a request, `pa_addr[23:12]` equals the table entry selected by `la_addr[15:12]`, as the table stood in the cycle of the request.
- R4: `pa_valid` equals `la_valid` delayed by exactly one cycle.
- R5: A table write takes effect on the clock edge where `tw_en` is high. A request in the same cycle as the write still sees the old entry, and requests in later cycles see the new one.
- R6: In a cycle after one where `la_valid` was low, `pa_addr` keeps its previous value.
- R7: One cycle after `tr_idx` is presented, `tr_data` holds that entry. If the same entry is written in that cycle, `tr_data` returns the value it held before the write.
- R8: A write changes only the entry selected by `tw_idx`. All other entries keep their values.
- R9: Any 12-bit value can be stored, including 0x000 and 0xFFF. Two entries may hold the same page number, and both then translate to that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| la_valid | input | 1 | Logical address is valid in this cycle |
| la_addr | input | 16 | Logical address; bits [15:12] select the entry |
| tw_en | input | 1 | Table write enable |
| tw_idx | input | 4 | Entry to write |
| tw_data | input | 12 | Page number to store |
| tr_idx | input | 4 | Entry to read back |
| tr_data | output | 12 | Registered read-back data |
| pa_valid | output | 1 | Physical address is valid |
| pa_addr | output | 24 | Physical address {page number, offset} |

## Verification
The bench targets the case where a write and a lookup of the same entry land in one cycle. A design that forwarded the new value would translate that request to the new page one cycle too early, and a read of that entry would return the new value instead of the old one. It runs lookups in every page straight after reset and with offsets 0x000 and 0xFFF. An identity map that was not loaded, or an offset that was not passed through, would show up as a wrong page or wrong low bits. It also stores 0x000, 0xFFF and one page number in two entries, and reads back the whole table, so a write that decoded the wrong index or spilled into a neighbouring entry is caught. Idle cycles check that `pa_addr` holds its value, which catches a design that keeps translating when no request is present.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int DEF_LA_W  = 16;
  localparam int DEF_IDX_W = 4;
  localparam int DEF_PPN_W = 12;
endpackage

// File: rtl/pmap_table.sv
module pmap_table #(
  parameter int IDX_W = 4,
  parameter int PPN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PPN_W-1:0] ent [DEPTH];

  // Storage: reset loads an identity map; one write per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= PPN_W'(i);
    end else if (wr_en) begin
      ent[wr_idx] <= wr_data;
    end
  end

  // Lookup sees the contents before this cycle's write.
  assign lk_ppn = ent[lk_idx];

  // Registered read-back: on an index collision it returns the old value.
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= ent[rd_idx];
  end
endmodule

// File: rtl/pmap_outreg.sv
module pmap_outreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_addr,
  output logic         out_valid,
  output logic [W-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= in_addr;
    end
  end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
#(
  parameter int LA_W  = DEF_LA_W,
  parameter int IDX_W = DEF_IDX_W,
  parameter int PPN_W = DEF_PPN_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          la_valid,
  input  logic [LA_W-1:0]               la_addr,
  input  logic                          tw_en,
  input  logic [IDX_W-1:0]              tw_idx,
  input  logic [PPN_W-1:0]              tw_data,
  input  logic [IDX_W-1:0]              tr_idx,
  output logic [PPN_W-1:0]              tr_data,
  output logic                          pa_valid,
  output logic [PPN_W+LA_W-IDX_W-1:0]   pa_addr
);
  localparam int OFF_W = LA_W - IDX_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic [IDX_W-1:0] page_idx;
  logic [OFF_W-1:0] page_off;
  logic [PPN_W-1:0] page_ppn;
  logic [PA_W-1:0]  phys_next;

  assign page_idx  = la_addr[LA_W-1:OFF_W];
  assign page_off  = la_addr[OFF_W-1:0];
  assign phys_next = {page_ppn, page_off};

  pmap_table #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tw_en),
    .wr_idx  (tw_idx),
    .wr_data (tw_data),
    .lk_idx  (page_idx),
    .lk_ppn  (page_ppn),
    .rd_idx  (tr_idx),
    .rd_data (tr_data)
  );

  pmap_outreg #(.W(PA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (la_valid),
    .in_addr   (phys_next),
    .out_valid (pa_valid),
    .out_addr  (pa_addr)
  );
endmodule

// File: rtl/pmap_xlate_chk.sv
module pmap_xlate_chk #(
  parameter int LA_W  = 16,
  parameter int IDX_W = 4,
  parameter int PPN_W = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        la_valid,
  input logic [LA_W-1:0]             la_addr,
  input logic                        tw_en,
  input logic [IDX_W-1:0]            tw_idx,
  input logic [PPN_W-1:0]            tw_data,
  input logic [IDX_W-1:0]            tr_idx,
  input logic [PPN_W-1:0]            tr_data,
  input logic                        pa_valid,
  input logic [PPN_W+LA_W-IDX_W-1:0] pa_addr
);
  localparam int OFF_W = LA_W - IDX_W;
  localparam int PA_W  = PPN_W + OFF_W;

  // Previous-cycle write, held in the checker.
  logic             w_d;
  logic [IDX_W-1:0] wi_d;
  logic [PPN_W-1:0] wd_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      w_d <= 1'b0; wi_d <= '0; wd_d <= '0;
    end else begin
      w_d <= tw_en; wi_d <= tw_idx; wd_d <= tw_data;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pa_valid && pa_addr == '0 && tr_data == '0));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
    la_valid |=> pa_addr[OFF_W-1:0] == $past(la_addr[OFF_W-1:0]));

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
    la_valid |=> pa_valid);

  assert_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !la_valid |=> !pa_valid);

  assert_new_entry_used_R5: assert property (@(posedge clk) disable iff (rst)
    (w_d && la_valid && la_addr[LA_W-1:OFF_W] == wi_d)
      |=> pa_addr[PA_W-1:OFF_W] == $past(wd_d));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !la_valid |=> $stable(pa_addr));

  assert_readback_R7: assert property (@(posedge clk) disable iff (rst)
    (w_d && tr_idx == wi_d) |=> tr_data == $past(wd_d));
endmodule

bind pmap_xlate pmap_xlate_chk #(.LA_W(LA_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) u_chk (.*);

// File: tb/pmap_xlate_tb.sv
module pmap_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        la_valid = 1'b0;
  logic [15:0] la_addr = '0;
  logic        tw_en = 1'b0;
  logic [3:0]  tw_idx = '0;
  logic [11:0] tw_data = '0;
  logic [3:0]  tr_idx = '0;
  logic [11:0] tr_data;
  logic        pa_valid;
  logic [23:0] pa_addr;

  always #2.5 clk = ~clk;

  pmap_xlate u_dut (.*);

  typedef struct { logic [23:0] pa; string tag; } exp_t;
  exp_t        pq[$];
  logic [11:0] rq[$];
  string       rtag[$];
  logic [11:0] model [16];
  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit done = 0;
  bit rd_flag_now = 0;
  bit rd_flag_d = 0;
  bit exp_v_d = 0;
  logic [23:0] last_pa = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; expectations use the table before the write.
  task automatic drive(input bit v, input logic [15:0] a, input bit we, input logic [3:0] wi,
                       input logic [11:0] wd, input bit rc, input logic [3:0] ri, input string tag);
    exp_t e;
    @(negedge clk);
    la_valid = v; la_addr = a; tw_en = we; tw_idx = wi; tw_data = wd;
    tr_idx = ri; rd_flag_now = rc;
    if (v) begin
      e.pa = {model[a[15:12]], a[11:0]};
      e.tag = tag;
      pq.push_back(e);
    end
    if (rc) begin
      rq.push_back(model[ri]);
      rtag.push_back(tag);
    end
    if (we) model[wi] = wd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 16'h0, 0, 4'h0, 12'h0, 0, 4'h0, "");
  endtask

  always @(posedge clk) begin
    exp_v_d   <= la_valid;
    rd_flag_d <= rd_flag_now;
  end

  // Monitor: compares outputs just after each edge.
  always @(posedge clk) begin
    #1;
    if (run) begin
      if (pa_valid) begin
        if (pq.size() == 0) chk(0, "R4 unexpected pa_valid", 32'(pa_valid), 32'h0);
        else begin
          exp_t e;
          e = pq.pop_front();
          chk(pa_addr == e.pa, e.tag, 32'(pa_addr), 32'(e.pa));
        end
        last_pa = pa_addr;
      end else begin
        chk(!exp_v_d, "R4 missing pa_valid", 32'(pa_valid), 32'(exp_v_d));
        chk(pa_addr == last_pa, "R6 hold when idle", 32'(pa_addr), 32'(last_pa));
      end
      if (rd_flag_d) begin
        logic [11:0] x;
        string t;
        x = rq.pop_front();
        t = rtag.pop_front();
        chk(tr_data == x, t, 32'(tr_data), 32'(x));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 12'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    chk(pa_valid == 1'b0, "R1 reset pa_valid", 32'(pa_valid), 32'h0);
    chk(pa_addr == 24'h0, "R1 reset pa_addr", 32'(pa_addr), 32'h0);
    chk(tr_data == 12'h0, "R1 reset tr_data", 32'(tr_data), 32'h0);
    rst = 1'b0;
    run = 1'b1;

    // R1: identity map in every page, with read-back of each entry
    for (int i = 0; i < 16; i++)
      drive(1, {4'(i), 12'(i * 12'h111)}, 0, 4'h0, 12'h0, 1, 4'(i), "R1 identity map");
    // R2: offset extremes
    drive(1, 16'h7000, 0, 4'h0, 12'h0, 0, 4'h0, "R2 offset 0x000");
    drive(1, 16'h7FFF, 0, 4'h0, 12'h0, 0, 4'h0, "R2 offset 0xFFF");
    idle(2);

    // R5/R7: write and lookup/read of the same entry in one cycle sees the old value
    drive(1, 16'h3456, 1, 4'h3, 12'hABC, 1, 4'h3, "R5 same-cycle old entry / R7 collision");
    drive(1, 16'h3457, 0, 4'h0, 12'h0, 1, 4'h3, "R5 next-cycle new entry / R7 readback");
    idle(1);

    // R9: extreme values and aliasing
    drive(0, 16'h0, 1, 4'hF, 12'hFFF, 0, 4'h0, "");
    drive(0, 16'h0, 1, 4'h0, 12'h000, 0, 4'h0, "");
    drive(0, 16'h0, 1, 4'h5, 12'hABC, 0, 4'h0, "");
    drive(1, 16'hF123, 0, 4'h0, 12'h0, 0, 4'h0, "R9 value 0xFFF");
    drive(1, 16'h0FED, 0, 4'h0, 12'h0, 0, 4'h0, "R9 value 0x000");
    drive(1, 16'h5001, 0, 4'h0, 12'h0, 0, 4'h0, "R9 alias entry 5");
    drive(1, 16'h3001, 0, 4'h0, 12'h0, 0, 4'h0, "R9 alias entry 3");
    idle(3);

    // R8: full read-back after the writes
    for (int i = 0; i < 16; i++)
      drive(0, 16'h0, 0, 4'h0, 12'h0, 1, 4'(i), "R8 other entries untouched");

    // R3: streaming lookups with writes interleaved
    for (int i = 0; i < 48; i++) begin
      bit we;
      we = (i % 3 == 0);
      drive(i % 5 != 4, {4'((i * 7) % 16), 12'(i * 37)}, we, 4'((i * 5) % 16),
            12'(i * 91 + 5), 0, 4'h0, "R3 streaming translation");
    end
    for (int i = 0; i < 16; i++)
      drive(1, {4'(i), 12'h800}, 0, 4'h0, 12'h0, 1, 4'(i), "R3 final table lookup");
    idle(4);

    chk(pq.size() == 0, "R4 all requests answered", 32'(pq.size()), 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule